// File: doc/BRIEF.md
# Dynamic Per-Bank Refresh Scheduler

This block decides, for one DRAM rank, when a per-bank refresh is sent and to which bank. It does not cycle through the banks in a fixed order. Each bank keeps a count of refreshes it owes. A pulse from an external interval timer adds one owed refresh to every bank. A bank whose request queue is empty is refreshed first, while the other banks keep serving traffic. Banks with queued reads can defer their refreshes until the debt reaches a hard cap. At the cap the refresh is forced and a stall flag is raised so the request scheduler holds off that bank.

When the controller drains a batch of writes, latency does not matter. In that mode the block pays off owed refreshes on any bank, whether or not its queue holds requests. Once nothing is owed, it refreshes each bank one interval ahead of time. The next interval pulse for that bank is then absorbed instead of adding debt.

Only one refresh runs at a time, which limits peak power. After a refresh is issued, no new one starts until the configured refresh latency has elapsed. A bank that the controller reports as refreshing is never chosen.

Top module: `dyn_refresh_sched`

## Requirements
- R1: During and after reset, `ref_fire_o` and `stall_req_o` are low and no refresh is issued until the first `interval_tick_i` has been sampled. This holds even if `drain_wr_i` is high.
- R2: Each sampled `interval_tick_i` adds one owed refresh to every bank. While `drain_wr_i` is low and a bank's `queue_empty_i` bit is 0, that bank's owed refresh is postponed and not issued.
- R3: With `drain_wr_i` low, a bank that owes a refresh and has `queue_empty_i` bit 1 is refreshed. When several such banks qualify, the lowest bank index goes first.
- R4: A bank whose `refreshing_i` bit is 1 is never selected in the cycle that bit is sampled.
- R5: `ref_fire_o` is a one-cycle pulse, and `ref_bank_o` carries the refreshed bank's binary index in that cycle. Two pulses are always at least `REF_LAT` cycles apart.
- R6: With `drain_wr_i` high, owed refreshes are issued regardless of `queue_empty_i`, lowest bank index first. They take priority over refreshes issued ahead of time.
- R7: With `drain_wr_i` high and no refresh owed by an eligible bank, a bank with zero debt and no advance already taken is refreshed ahead, lowest index first. At most one advance is held per bank. The next interval tick clears that advance instead of adding debt.
- R8: A bank whose debt reaches `CREDIT_CAP` is refreshed regardless of queue state and mode, ahead of all other candidates, lowest index first. `stall_req_o` is high exactly while at least one bank's debt equals `CREDIT_CAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| queue_empty_i | input | NUM_BANKS | Bit b is 1 when bank b has no queued requests |
| refreshing_i | input | NUM_BANKS | Bit b is 1 while bank b is reported as refreshing |
| drain_wr_i | input | 1 | Controller is draining a write batch |
| interval_tick_i | input | 1 | One-cycle pulse from the refresh-interval timer |
| ref_fire_o | output | 1 | One-cycle refresh issue pulse |
| ref_bank_o | output | $clog2(NUM_BANKS) | Binary index of the refreshed bank, valid with `ref_fire_o` |
| stall_req_o | output | 1 | A bank is at the postponement cap and must be refreshed |

## Verification
A debt counter that is off by one shows up in one of three ways. A bank gets refreshed when it owes nothing. A bank stays silent even though its queue is empty. Or `stall_req_o` rises one tick early or late. Each of these appears at the ports within one decision cycle after the tick or queue change that exposes it. A faulty lockout timer or a wrong priority shows up in the very next issue pulse, as a pulse gap shorter than the refresh latency or as a bank index that breaks the lowest-index order. A lost advance marker is caught when a tick in non-drain mode, with all queues empty, produces refreshes that should have been absorbed.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    localparam int DEF_BANKS = 8;
    localparam int DEF_CAP   = 8;
    localparam int DEF_LAT   = 70;

    // class of the candidate chosen in a cycle, highest priority first
    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_FORCED = 2'd1,
        KIND_OWED   = 2'd2,
        KIND_AHEAD  = 2'd3
    } pick_kind_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/refsched_credit.sv
module refsched_credit #(
    parameter int CAP = refsched_pkg::DEF_CAP,
    parameter int CW  = refsched_pkg::width_of(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          served,
    output logic          owes,
    output logic          at_cap,
    output logic          can_ahead,
    output logic [CW-1:0] debt
);
    localparam logic [CW-1:0] CAP_V = CW'(CAP);

    logic ahead;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt  <= '0;
            ahead <= 1'b0;
        end else if (served && debt != '0) begin
            if (!tick) debt <= debt - 1'b1;
        end else if (served) begin
            // advance refresh: a coincident tick consumes it at once
            ahead <= !tick;
        end else if (tick) begin
            if (ahead)              ahead <= 1'b0;
            else if (debt != CAP_V) debt  <= debt + 1'b1;
        end
    end

    assign owes      = (debt != '0);
    assign at_cap    = (debt == CAP_V);
    assign can_ahead = (debt == '0) && !ahead;

    // R8
    no_credit_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        debt <= CAP_V);
    // R7
    ahead_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ahead |-> (debt == '0));
    // R7
    single_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        (served && ahead) |-> owes);

endmodule

// File: rtl/refsched_picker.sv
module refsched_picker
    import refsched_pkg::*;
#(
    parameter int NB = refsched_pkg::DEF_BANKS,
    parameter int BW = refsched_pkg::width_of(NB)
) (
    input  logic [NB-1:0] owes,
    input  logic [NB-1:0] at_cap,
    input  logic [NB-1:0] can_ahead,
    input  logic [NB-1:0] queue_empty,
    input  logic [NB-1:0] refreshing,
    input  logic          drain,
    output logic          valid,
    output logic [BW-1:0] bank,
    output pick_kind_e    kind
);
    logic [NB-1:0] forced_v, owed_v, ahead_v, chosen_v;

    function automatic logic [BW-1:0] lowest(input logic [NB-1:0] v);
        logic [BW-1:0] r;
        r = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (v[i]) r = BW'(i);
        end
        return r;
    endfunction

    always_comb begin
        forced_v = at_cap & ~refreshing;
        owed_v   = owes & ~refreshing & (drain ? {NB{1'b1}} : queue_empty);
        ahead_v  = drain ? (can_ahead & ~refreshing) : '0;
        if (|forced_v) begin
            kind = KIND_FORCED; chosen_v = forced_v;
        end else if (|owed_v) begin
            kind = KIND_OWED;   chosen_v = owed_v;
        end else if (|ahead_v) begin
            kind = KIND_AHEAD;  chosen_v = ahead_v;
        end else begin
            kind = KIND_NONE;   chosen_v = '0;
        end
        valid = (kind != KIND_NONE);
        bank  = lowest(chosen_v);
    end

endmodule

// File: rtl/refsched_lockout.sv
module refsched_lockout #(
    parameter int LAT = refsched_pkg::DEF_LAT,
    parameter int LW  = refsched_pkg::width_of(LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (start)       remain <= (LAT > 1) ? LW'(LAT - 1) : '0;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R5
    no_early_fire_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/dyn_refresh_sched.sv
module dyn_refresh_sched
    import refsched_pkg::*;
#(
    parameter int NUM_BANKS  = refsched_pkg::DEF_BANKS,
    parameter int CREDIT_CAP = refsched_pkg::DEF_CAP,
    parameter int REF_LAT    = refsched_pkg::DEF_LAT,
    localparam int BW        = refsched_pkg::width_of(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] queue_empty_i,
    input  logic [NUM_BANKS-1:0] refreshing_i,
    input  logic                 drain_wr_i,
    input  logic                 interval_tick_i,
    output logic                 ref_fire_o,
    output logic [BW-1:0]        ref_bank_o,
    output logic                 stall_req_o
);
    localparam int CW = refsched_pkg::width_of(CREDIT_CAP + 1);

    logic [NUM_BANKS-1:0] owes, at_cap, can_ahead, served;
    logic [CW-1:0]        debt [NUM_BANKS];
    logic                 armed, busy, pick_valid, fire_d;
    logic [BW-1:0]        pick_bank;
    pick_kind_e           pick_kind;

    assign fire_d = armed && !busy && pick_valid;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign served[b] = fire_d && (pick_bank == BW'(b));
            refsched_credit #(.CAP(CREDIT_CAP), .CW(CW)) u_credit (
                .clk       (clk),
                .rst       (rst),
                .tick      (interval_tick_i),
                .served    (served[b]),
                .owes      (owes[b]),
                .at_cap    (at_cap[b]),
                .can_ahead (can_ahead[b]),
                .debt      (debt[b])
            );
        end
    endgenerate

    refsched_picker #(.NB(NUM_BANKS), .BW(BW)) u_picker (
        .owes        (owes),
        .at_cap      (at_cap),
        .can_ahead   (can_ahead),
        .queue_empty (queue_empty_i),
        .refreshing  (refreshing_i),
        .drain       (drain_wr_i),
        .valid       (pick_valid),
        .bank        (pick_bank),
        .kind        (pick_kind)
    );

    refsched_lockout #(.LAT(REF_LAT)) u_lockout (
        .clk   (clk),
        .rst   (rst),
        .start (fire_d),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            ref_fire_o <= 1'b0;
            ref_bank_o <= '0;
        end else begin
            if (interval_tick_i) armed <= 1'b1;
            ref_fire_o <= fire_d;
            if (fire_d) ref_bank_o <= pick_bank;
        end
    end

    assign stall_req_o = |at_cap;

    // R1
    no_fire_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !fire_d);
    // R4
    skip_refreshing_chk: assert property (@(posedge clk) disable iff (rst)
        fire_d |-> !refreshing_i[pick_bank]);
    // R8
    forced_first_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_d && stall_req_o && (at_cap & ~refreshing_i) != '0)
            |-> (pick_kind == KIND_FORCED));
    // R5
    one_hot_serve_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(served));

endmodule

// File: tb/dyn_refresh_sched_tb.sv
module dyn_refresh_sched_tb;
    localparam int NB  = 8;
    localparam int CAP = 8;
    localparam int LAT = 6;
    localparam int BW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] qe = '0;
    logic [NB-1:0] refr = '0;
    logic          drain = 1'b0;
    logic          tick = 1'b0;
    logic          fire;
    logic [BW-1:0] bank;
    logic          stall;

    int n_checks = 0;
    int n_fail   = 0;
    int fire_cnt = 0;
    int cyc      = 0;
    int last_fire = -1;
    int    exp_bank[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    dyn_refresh_sched #(.NUM_BANKS(NB), .CREDIT_CAP(CAP), .REF_LAT(LAT)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .queue_empty_i   (qe),
        .refreshing_i    (refr),
        .drain_wr_i      (drain),
        .interval_tick_i (tick),
        .ref_fire_o      (fire),
        .ref_bank_o      (bank),
        .stall_req_o     (stall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int b, input string tag);
        exp_bank.push_back(b);
        exp_tag.push_back(tag);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; qe = '0; refr = '0; drain = 1'b0; tick = 1'b0;
        cycles(3);
        rst = 1'b0;
        last_fire = -1;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cycles(1);
        tick = 1'b0;
    endtask

    // monitor: pops expected issues as they appear
    always @(negedge clk) begin
        if (!rst && fire) begin
            fire_cnt++;
            if (last_fire >= 0)
                chk(cyc - last_fire >= LAT, "R5 gap", cyc - last_fire, LAT);
            last_fire = cyc;
            if (exp_bank.size() == 0) begin
                chk(1'b0, "R2/R7 unexpected refresh", int'(bank), -1);
            end else begin
                int    eb;
                string et;
                eb = exp_bank.pop_front();
                et = exp_tag.pop_front();
                chk(int'(bank) == eb, et, int'(bank), eb);
            end
        end
    end

    initial begin
        int fc;
        // R1 reset state
        rst = 1'b1;
        cycles(2);
        chk(fire == 1'b0, "R1 reset fire", fire, 0);
        chk(stall == 1'b0, "R1 reset stall", stall, 0);
        do_reset();

        // R1: no issue before first tick even while draining
        drain = 1'b1; qe = '1;
        fc = fire_cnt;
        cycles(20);
        chk(fire_cnt == fc, "R1 no refresh before tick", fire_cnt - fc, 0);
        drain = 1'b0; qe = '0;
        cycles(2);

        // R2: tick, all queues busy -> postponed
        pulse_tick();
        fc = fire_cnt;
        cycles(25);
        chk(fire_cnt == fc, "R2 postponed while busy", fire_cnt - fc, 0);
        chk(stall == 1'b0, "R8 no stall below cap", stall, 0);

        // R3: idle banks 2 and 5, lowest first
        push(2, "R3 idle bank lowest first");
        push(5, "R3 idle bank second");
        qe = 8'b0010_0100;
        cycles(3 * LAT);
        qe = '0;
        cycles(4);

        // R4: bank 0 refreshing, banks 0 and 3 idle -> bank 3
        push(3, "R4 refreshing bank skipped");
        refr = 8'b0000_0001;
        qe   = 8'b0000_1001;
        cycles(3 * LAT);
        refr = '0; qe = '0;
        cycles(4);

        // R6 then R7: drain pays 0,1,4,6,7 then advances 0..7
        push(0, "R6 drain owed"); push(1, "R6 drain owed");
        push(4, "R6 drain owed"); push(6, "R6 drain owed");
        push(7, "R6 drain owed");
        for (int b = 0; b < NB; b++) push(b, "R7 advance refresh");
        drain = 1'b1;
        cycles(16 * LAT);
        chk(exp_bank.size() == 0, "R6 drain issues done", exp_bank.size(), 0);
        fc = fire_cnt;
        cycles(3 * LAT);
        chk(fire_cnt == fc, "R7 one advance per bank", fire_cnt - fc, 0);
        drain = 1'b0;
        cycles(2);

        // R7: tick absorbed by advance -> nothing owed even when idle
        pulse_tick();
        qe = '1;
        fc = fire_cnt;
        cycles(30);
        chk(fire_cnt == fc, "R7 tick absorbed", fire_cnt - fc, 0);
        qe = '0;

        // R8: eight ticks with busy queues -> cap, stall, forced order
        do_reset();
        tick = 1'b1;
        cycles(7);
        chk(stall == 1'b0, "R8 stall low below cap", stall, 0);
        for (int b = 0; b < NB; b++) push(b, "R8 forced order");
        fc = fire_cnt;
        cycles(1);
        tick = 1'b0;
        chk(stall == 1'b1, "R8 stall at cap", stall, 1);
        chk(fire_cnt == fc, "R8 forced not yet issued", fire_cnt - fc, 0);
        cycles(NB * LAT + 10);
        chk(exp_bank.size() == 0, "R8 all forced issued", exp_bank.size(), 0);
        chk(stall == 1'b0, "R8 stall cleared", stall, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule